// File: doc/BRIEF.md
# Snoop-Preempting Dual-Master Bus Arbiter

This block decides which of two masters, A and B, drives a shared bus. In normal operation it hands the bus out by request and grant, one owner at a time, and it alternates fairly when both masters compete. The current owner keeps the bus for as long as its request stays high.

Each master also watches the bus for addresses that hit a dirty line in its own cache. Master A reports such a hit on `snp_dirty_a`, and master B reports one on `snp_dirty_b`. Either report overrides the normal rotation.

- When A reports a hit, B is told to back off. A is then granted the bus so that it can write the line back.
- When B reports a hit, A is given a retry. B then takes the bus to drain its line.

The back-off or retry stays active until the draining master pulses `wb_done`. After that, the master that was pushed off gets priority, so it can reissue its interrupted transfer.

All outputs are decoded from registered state. The asynchronous reset is released through a two-stage synchronizer.

Top module: `coh_arb_top`

## Requirements
- R1: While reset is active, and for as long as it stays active, all four outputs (`gnt_a`, `gnt_b`, `backoff_b`, `retry_a`) are 0. Reset takes effect without waiting for a clock edge.
- R2: `gnt_a` and `gnt_b` are never 1 at the same time.
- R3: If the bus is idle and a single master requests, that master's grant rises one clock edge after the request is sampled.
- R4: An owner keeps its grant for as long as it holds its request high, even when the other master is also requesting.
- R5: If both masters request while the bus is idle, the grant goes to the master that did not own the bus last. After reset, A wins this tie.
- R6: If the owner drops its request and the other master is requesting, the grant moves to the other master at the next edge. If the other master is not requesting, the bus goes idle.
- R7: When `snp_dirty_a` is sampled high outside a drain, the next edge sets `backoff_b` with no grant active. The edge after that raises `gnt_a` while `backoff_b` stays high.
- R8: During A's write-back, `backoff_b` and `gnt_a` stay high until `wb_done` is sampled, and both fall at the following edge.
- R9: When `snp_dirty_b` is sampled high outside a drain, and `snp_dirty_a` is low, the next edge sets `retry_a` with no grant active. The edge after that raises `gnt_b` while `retry_a` stays high. `retry_a` falls at the edge after `wb_done` is sampled.
- R10: At the end of a drain, the master that was preempted wins if both masters request. Otherwise the single requester is granted, or the bus goes idle. When the bus goes idle this way, the preempted master keeps the tie priority.
- R11: If both snoop inputs are high in the same cycle, A's hit is serviced (back-off path).
- R12: Snoop inputs are ignored during a back-off, retry or drain. `wb_done` is ignored outside a drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_a | input | 1 | Bus request from master A |
| req_b | input | 1 | Bus request from master B |
| snp_dirty_a | input | 1 | Master A snoop hit a modified line |
| snp_dirty_b | input | 1 | Master B snoop hit a modified line |
| wb_done | input | 1 | Last beat of the draining master's write-back |
| gnt_a | output | 1 | Bus grant to master A |
| gnt_b | output | 1 | Bus grant to master B |
| backoff_b | output | 1 | Forces master B off the bus |
| retry_a | output | 1 | Forces master A to abandon its transfer |

## Verification
The assertions assume two things about the inputs. First, a snoop report can arrive in any cycle. Second, `wb_done` is only meaningful while a drain grant is active. For that reason, every drain property is conditioned on the grant and the back-off or retry being visible together, rather than on `wb_done` alone.

The stimulus keeps `wb_done` high outside a drain only on purpose, to show that it is ignored. It also raises both snoop inputs at once in exactly one case, where A's hit must take precedence.

Request changes are applied away from the clock edge, so every expected output belongs to exactly one registered state.

// File: rtl/coh_arb_pkg.sv
package coh_arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_OWN_A = 3'd1,
    ST_OWN_B = 3'd2,
    ST_BOFF_B = 3'd3,
    ST_DRN_A = 3'd4,
    ST_RTY_A = 3'd5,
    ST_DRN_B = 3'd6
  } arb_st_e;

  typedef enum logic {
    MST_A = 1'b0,
    MST_B = 1'b1
  } mst_e;
endpackage

// File: rtl/coh_arb_rst_sync.sv
module coh_arb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/coh_arb_pick.sv
module coh_arb_pick
  import coh_arb_pkg::*;
(
  input  logic req_a,
  input  logic req_b,
  input  mst_e fav,
  output logic take_a,
  output logic take_b
);
  always_comb begin
    take_a = req_a & (~req_b | (fav == MST_A));
    take_b = req_b & (~req_a | (fav == MST_B));
  end
endmodule

// File: rtl/coh_arb_fsm.sv
module coh_arb_fsm
  import coh_arb_pkg::*;
#(
  parameter bit A_HIT_FIRST = 1'b1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_a,
  input  logic    req_b,
  input  logic    hit_a,
  input  logic    hit_b,
  input  logic    drain_end,
  output arb_st_e st
);
  arb_st_e st_q, st_d;
  mst_e    fav_q, fav_d, pick_fav;
  logic    fav_en;
  logic    take_a, take_b;
  logic    use_hit_a, use_hit_b;

  generate
    if (A_HIT_FIRST) begin : g_a_first
      assign use_hit_a = hit_a;
      assign use_hit_b = hit_b & ~hit_a;
    end else begin : g_b_first
      assign use_hit_a = hit_a & ~hit_b;
      assign use_hit_b = hit_b;
    end
  endgenerate

  // after a drain the preempted master is favoured
  always_comb begin
    case (st_q)
      ST_DRN_A: pick_fav = MST_B;
      ST_DRN_B: pick_fav = MST_A;
      default:  pick_fav = fav_q;
    endcase
  end

  coh_arb_pick u_pick (
    .req_a  (req_a),
    .req_b  (req_b),
    .fav    (pick_fav),
    .take_a (take_a),
    .take_b (take_b)
  );

  always_comb begin
    st_d   = st_q;
    fav_d  = fav_q;
    fav_en = 1'b0;
    case (st_q)
      ST_IDLE, ST_OWN_A, ST_OWN_B: begin
        if (use_hit_a) begin
          st_d = ST_BOFF_B;
        end else if (use_hit_b) begin
          st_d = ST_RTY_A;
        end else if (st_q == ST_IDLE) begin
          if (take_a) begin
            st_d = ST_OWN_A; fav_d = MST_B; fav_en = 1'b1;
          end else if (take_b) begin
            st_d = ST_OWN_B; fav_d = MST_A; fav_en = 1'b1;
          end
        end else if (st_q == ST_OWN_A) begin
          if (!req_a) begin
            if (req_b) begin
              st_d = ST_OWN_B; fav_d = MST_A; fav_en = 1'b1;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end else begin
          if (!req_b) begin
            if (req_a) begin
              st_d = ST_OWN_A; fav_d = MST_B; fav_en = 1'b1;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
      end
      ST_BOFF_B: st_d = ST_DRN_A;
      ST_RTY_A:  st_d = ST_DRN_B;
      ST_DRN_A, ST_DRN_B: begin
        if (drain_end) begin
          fav_en = 1'b1;
          if (take_a) begin
            st_d = ST_OWN_A; fav_d = MST_B;
          end else if (take_b) begin
            st_d = ST_OWN_B; fav_d = MST_A;
          end else begin
            st_d  = ST_IDLE;
            fav_d = pick_fav;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fav_q <= MST_A;
    else if (fav_en) fav_q <= fav_d;
  end

  assign st = st_q;
endmodule

// File: rtl/coh_arb_top.sv
module coh_arb_top
  import coh_arb_pkg::*;
#(
  parameter bit          A_HIT_FIRST = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_a,
  input  logic req_b,
  input  logic snp_dirty_a,
  input  logic snp_dirty_b,
  input  logic wb_done,
  output logic gnt_a,
  output logic gnt_b,
  output logic backoff_b,
  output logic retry_a
);
  logic    rst_n_int;
  arb_st_e st;

  coh_arb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  coh_arb_fsm #(.A_HIT_FIRST(A_HIT_FIRST)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .req_a     (req_a),
    .req_b     (req_b),
    .hit_a     (snp_dirty_a),
    .hit_b     (snp_dirty_b),
    .drain_end (wb_done),
    .st        (st)
  );

  always_comb begin
    gnt_a     = (st == ST_OWN_A)  || (st == ST_DRN_A);
    gnt_b     = (st == ST_OWN_B)  || (st == ST_DRN_B);
    backoff_b = (st == ST_BOFF_B) || (st == ST_DRN_A);
    retry_a   = (st == ST_RTY_A)  || (st == ST_DRN_B);
  end
endmodule

// File: rtl/coh_arb_chk.sv
module coh_arb_chk (
  input logic clk,
  input logic rst_n,
  input logic req_a,
  input logic req_b,
  input logic snp_dirty_a,
  input logic snp_dirty_b,
  input logic wb_done,
  input logic gnt_a,
  input logic gnt_b,
  input logic backoff_b,
  input logic retry_a
);
  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt_a && gnt_b));

  p_owner_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_a && req_a && !backoff_b && !retry_a && !snp_dirty_a && !snp_dirty_b) |=> gnt_a);

  p_hit_a_backoff_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_dirty_a && !backoff_b && !retry_a) |=> (backoff_b && !gnt_a && !gnt_b));

  p_backoff_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(backoff_b) |=> (gnt_a && backoff_b));

  p_drain_a_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (backoff_b && gnt_a && !wb_done) |=> (backoff_b && gnt_a));

  p_drain_a_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (backoff_b && gnt_a && wb_done) |=> !backoff_b);

  p_hit_b_retry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_dirty_b && !snp_dirty_a && !backoff_b && !retry_a) |=> (retry_a && !gnt_a && !gnt_b));

  p_retry_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retry_a) |=> (gnt_b && retry_a));

  p_drain_b_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_a && gnt_b && wb_done) |=> !retry_a);

  p_single_preempt_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(backoff_b && retry_a));
endmodule

bind coh_arb_top coh_arb_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_a       (req_a),
  .req_b       (req_b),
  .snp_dirty_a (snp_dirty_a),
  .snp_dirty_b (snp_dirty_b),
  .wb_done     (wb_done),
  .gnt_a       (gnt_a),
  .gnt_b       (gnt_b),
  .backoff_b   (backoff_b),
  .retry_a     (retry_a)
);

// File: tb/sim_coh_arb_top.sv
`timescale 1ns/1ps
module sim_coh_arb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_a = 1'b0, req_b = 1'b0, snp_dirty_a = 1'b0, snp_dirty_b = 1'b0, wb_done = 1'b0;
  logic gnt_a, gnt_b, backoff_b, retry_a;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  coh_arb_top u0 (
    .clk(clk), .rst_n(rst_n), .req_a(req_a), .req_b(req_b),
    .snp_dirty_a(snp_dirty_a), .snp_dirty_b(snp_dirty_b), .wb_done(wb_done),
    .gnt_a(gnt_a), .gnt_b(gnt_b), .backoff_b(backoff_b), .retry_a(retry_a)
  );

  // {req id, req_a req_b hit_a hit_b wb_done, exp gnt_a gnt_b backoff_b retry_a}
  // Requirements walked: R3 R4 R5 R6 R7 R8 R9 R10 R11 R12
  localparam logic [12:0] VEC [0:24] = '{
    {4'd3,  5'b00000, 4'b0000},
    {4'd3,  5'b10000, 4'b1000},
    {4'd4,  5'b11000, 4'b1000},
    {4'd4,  5'b11000, 4'b1000},
    {4'd6,  5'b01000, 4'b0100},
    {4'd4,  5'b11000, 4'b0100},
    {4'd6,  5'b10000, 4'b1000},
    {4'd6,  5'b00000, 4'b0000},
    {4'd5,  5'b11000, 4'b0100},
    {4'd6,  5'b00000, 4'b0000},
    {4'd5,  5'b11000, 4'b1000},
    {4'd6,  5'b01000, 4'b0100},
    {4'd7,  5'b01100, 4'b0010},
    {4'd7,  5'b01000, 4'b1010},
    {4'd12, 5'b01010, 4'b1010},
    {4'd8,  5'b01000, 4'b1010},
    {4'd10, 5'b11001, 4'b0100},
    {4'd9,  5'b11010, 4'b0001},
    {4'd9,  5'b11000, 4'b0101},
    {4'd10, 5'b11001, 4'b1000},
    {4'd11, 5'b11110, 4'b0010},
    {4'd12, 5'b00001, 4'b1010},
    {4'd10, 5'b00001, 4'b0000},
    {4'd10, 5'b11000, 4'b0100},
    {4'd12, 5'b00001, 4'b0000}
  };

  task automatic chk(input int rid, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: outputs {gnt_a,gnt_b,backoff_b,retry_a} actual %b expected %b", rid, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] v);
    {req_a, req_b, snp_dirty_a, snp_dirty_b, wb_done} = v;
  endtask

  initial begin
    // R1: outputs quiet during reset
    repeat (3) @(negedge clk);
    chk(1, {gnt_a, gnt_b, backoff_b, retry_a}, 4'b0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 25; i++) begin
      drive(VEC[i][8:4]);
      @(negedge clk);
      chk(int'(VEC[i][12:9]), {gnt_a, gnt_b, backoff_b, retry_a}, VEC[i][3:0]);
      chk(2, {1'b0, gnt_a & gnt_b, 2'b00}, 4'b0000); // R2
    end

    // R1: asynchronous reset while a grant is held
    drive(5'b10000);
    @(negedge clk);
    chk(3, {gnt_a, gnt_b, backoff_b, retry_a}, 4'b1000);
    #2 rst_n = 1'b0;
    #1 chk(1, {gnt_a, gnt_b, backoff_b, retry_a}, 4'b0000);
    drive(5'b00000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(1, {gnt_a, gnt_b, backoff_b, retry_a}, 4'b0000);

    // R5: tie right after reset goes to A
    drive(5'b11000);
    @(negedge clk);
    chk(5, {gnt_a, gnt_b, backoff_b, retry_a}, 4'b1000);
    drive(5'b00000);
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule